// File: doc/BRIEF.md
# Serial Run-Length Detector (Four in a Row)

This block watches a single serial bit `w`, sampled on each rising clock edge. It raises `z` once the last four samples are all equal, whether all zeros or all ones. It is a nine-state Moore machine. There is an idle state, a chain of four states that count zeros, and a chain of four states that count ones. The last state in each chain asserts `z`. That state holds for as long as the run goes on. A sample of the opposite value starts a count of one in the other chain.

The state is kept one flip-flop per state. The idle state is coded as the all-zero vector, so reset only clears registers. Flip-flop 0 reads 1 in every state except idle. The next-state function is a set of plain Boolean equations, one per flip-flop. The full state vector is brought out as a port so a board or bench can watch the machine move. The run length is a parameter, `RUN_LEN`, with a default of 4. The state vector has `2*RUN_LEN+1` bits.

Top module: `rlseq_detect`

## Requirements
- R1: Reset is synchronous and active high. An edge with `rst`=1 loads `state`=0 and `z`=0 whatever the value of `w`, including from a state that would otherwise hold.
- R2: `state` is always a legal code. Idle is all zeros. The other eight states each have bit 0 set plus exactly one of bits 1..8. Bits 1..4 mean 1..4 consecutive zeros seen, and bits 5..8 mean 1..4 consecutive ones seen.
- R3: A 0 sampled in idle or in any ones-chain state moves to bit 1 (one zero seen). Each further 0 moves up one bit, through bits 2 and 3 to bit 4.
- R4: A 1 sampled in idle or in any zeros-chain state moves to bit 5 (one one seen). Each further 1 moves up one bit, through bits 6 and 7 to bit 8.
- R5: In the four-zeros state (bit 4), another 0 stays there. In the four-ones state (bit 8), another 1 stays there.
- R6: `z` is 1 exactly when `state` is the four-zeros or four-ones code, and it changes on the same edge as `state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset to idle |
| w | input | 1 | Serial data bit, sampled each rising edge |
| z | output | 1 | Registered Moore output: a run of `RUN_LEN` equal bits is in progress |
| state | output | 2*RUN_LEN+1 | Current state vector, idle = all zeros |

## Verification
The embedded properties check four things on every cycle: that the state code is legal, that `z` agrees with the state, that each chain is entered from the right states, and that the terminal states hold. Two things only the bench's sweep shows: that the state tracks the true run length over arbitrary histories, and that the chains step through their middle states. The sweep applies every 8-bit input pattern after reset and compares each cycle against a run counter. It also shows reset overriding a holding state, because each reset arrives with `w`=1 just after a pattern that may end in the four-ones state.

// File: rtl/rlseq_pkg.sv
package rlseq_pkg;
  typedef enum logic [0:0] {
    POL_ZERO = 1'b0,
    POL_ONE  = 1'b1
  } run_pol_e;
endpackage

// File: rtl/rlseq_chain.sv
module rlseq_chain
  import rlseq_pkg::*;
#(
  parameter int       RUN_LEN = 4,
  parameter run_pol_e POL     = POL_ZERO
) (
  input  logic               w,
  input  logic               enter,
  input  logic [RUN_LEN-1:0] cur,
  output logic [RUN_LEN-1:0] nxt
);
  logic hit;
  assign hit = (POL == POL_ONE) ? w : ~w;

  assign nxt[0] = hit & enter;

  generate
    for (genvar k = 1; k < RUN_LEN - 1; k++) begin : g_mid
      assign nxt[k] = hit & cur[k-1];
    end
    if (RUN_LEN > 1) begin : g_last
      assign nxt[RUN_LEN-1] = hit & (cur[RUN_LEN-2] | cur[RUN_LEN-1]);
    end
  endgenerate
endmodule

// File: rtl/rlseq_guard.sv
module rlseq_guard #(
  parameter int NB = 9
) (
  input  logic [NB-1:0] q,
  output logic          legal
);
  logic idle, active;
  assign idle   = (q == '0);
  assign active = q[0] & $onehot(q[NB-1:1]);
  assign legal  = idle | active;
endmodule

// File: rtl/rlseq_detect.sv
module rlseq_detect
  import rlseq_pkg::*;
#(
  parameter int RUN_LEN = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   w,
  output logic                   z,
  output logic [2*RUN_LEN:0]     state
);
  localparam int NB    = 2 * RUN_LEN + 1;
  localparam int Z_TOP = RUN_LEN;
  localparam int O_BOT = RUN_LEN + 1;
  localparam int O_TOP = NB - 1;

  logic [NB-1:0]      st_q, st_d;
  logic               z_q;
  logic [RUN_LEN-1:0] zeros_q, ones_q, zeros_d, ones_d;
  logic               in_idle, legal;

  assign zeros_q = st_q[Z_TOP:1];
  assign ones_q  = st_q[O_TOP:O_BOT];
  assign in_idle = ~st_q[0];

  rlseq_chain #(.RUN_LEN(RUN_LEN), .POL(POL_ZERO)) u_zero (
    .w(w), .enter(in_idle | (|ones_q)), .cur(zeros_q), .nxt(zeros_d)
  );

  rlseq_chain #(.RUN_LEN(RUN_LEN), .POL(POL_ONE)) u_one (
    .w(w), .enter(in_idle | (|zeros_q)), .cur(ones_q), .nxt(ones_d)
  );

  rlseq_guard #(.NB(NB)) u_guard (.q(st_q), .legal(legal));

  assign st_d = legal ? {ones_d, zeros_d, 1'b1} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
      z_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      z_q  <= st_d[Z_TOP] | st_d[O_TOP];
    end
  end

  assign state = st_q;
  assign z     = z_q;

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == '0 && !z_q));
  // R2
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == '0) || (st_q[0] && $onehot(st_q[O_TOP:1])));
  // R3
  zero_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((in_idle || (|ones_q)) && !w) |=> st_q[1]);
  // R4
  one_entry_chk: assert property (@(posedge clk) disable iff (rst)
    ((in_idle || (|zeros_q)) && w) |=> st_q[O_BOT]);
  // R5
  zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q[Z_TOP] && !w) |=> st_q[Z_TOP]);
  // R5
  one_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q[O_TOP] && w) |=> st_q[O_TOP]);
  // R6
  moore_z_chk: assert property (@(posedge clk) disable iff (rst)
    z_q == (st_q[Z_TOP] | st_q[O_TOP]));
endmodule

// File: tb/sim_rlseq_detect.sv
module sim_rlseq_detect;
  localparam int L  = 4;
  localparam int NB = 2 * L + 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          w   = 1'b0;
  logic          z;
  logic [NB-1:0] state;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int last_v = 0;
  int run    = 0;

  rlseq_detect #(.RUN_LEN(L)) u0 (
    .clk(clk), .rst(rst), .w(w), .z(z), .state(state)
  );

  always #10 clk = ~clk;

  function automatic logic [NB-1:0] code_of(int pol, int n);
    int idx;
    if (n == 0) return '0;
    idx = (n > L) ? L : n;
    return {{(NB-1){1'b0}}, 1'b1} | ({{(NB-1){1'b0}}, 1'b1} << (pol != 0 ? L + idx : idx));
  endfunction

  task automatic check(bit ok, string tag, logic [NB-1:0] act, logic [NB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [NB-1:0] exp;
    logic          ez;
    bit            lg;
    exp = code_of(last_v, run);
    ez  = (run >= L);
    lg  = (state == '0) || (state[0] && $onehot(state[NB-1:1]));
    check(state == exp, tag, state, exp);
    // R6: z aligned with state
    check(z == ez, "R6", {{(NB-1){1'b0}}, z}, {{(NB-1){1'b0}}, ez});
    // R2: legal code at the port
    check(lg, "R2", state, exp);
  endtask

  task automatic do_reset();
    // R1: w=1 during reset to show reset wins
    rst = 1'b1;
    w   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    run = 0;
    last_v = 0;
    check(state == '0 && z == 1'b0, "R1", state, '0);
    rst = 1'b0;
  endtask

  task automatic step(bit wv);
    string tag;
    w = wv;
    @(posedge clk);
    @(negedge clk);
    if (run > 0 && int'(wv) == last_v) run++;
    else begin
      last_v = int'(wv);
      run = 1;
    end
    if (run > L) tag = "R5";
    else if (last_v == 0) tag = "R3";
    else tag = "R4";
    check_all(tag);
  endtask

  initial begin
    @(negedge clk);
    for (int s = 0; s < 256; s++) begin
      do_reset();
      for (int b = 0; b < 8; b++) step(s[b]);
    end
    // long runs stay in the terminal states (R5)
    do_reset();
    for (int i = 0; i < 10; i++) step(1'b1);
    do_reset();
    for (int i = 0; i < 10; i++) step(1'b0);
    for (int i = 0; i < 3; i++) step(1'b1);
    do_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule